// File: doc/BRIEF.md
# Display Controller Host Register File

This block is the host-facing register file of an eight-position dot-matrix character display controller. A processor reaches it over an asynchronous parallel bus: an active-low chip select, active-low read and write strobes, an active-low attribute select, five address lines and an 8-bit bidirectional data bus. The strobes pass through a synchronizer into the system clock domain. Each chip-select period commits at most one write.

Behind the bus sit five storage regions:
- a character byte for each position;
- a one-bit blink attribute for each position;
- a pointer that selects one of sixteen custom glyphs;
- the custom glyph rows, each five pixels wide;
- a control byte that holds intensity, attribute enable, global blink, self-test start and a clear request.

A clear request, and the end of a reset, start a self-timed sequence. The sequence blanks every position to the space code 20h and removes every attribute. It then waits three display-clock ticks before the block accepts host writes again. The scan, font and self-test logic that follow this block read its contents through dedicated read ports.

Top module: `dispreg_host_if`

## Requirements
- R1: A write commits once per chip-select period, on the first synchronized cycle in which chip select and write strobe are both low. Data that changes later in the same period is not stored.
- R2: With the attribute select low, the access goes to the attribute bit of the position given by A2..A0, whatever A4..A3 hold. A write stores D0 (1 = flashing, 0 = steady). A read returns the bit in D0, with D7..D1 zero.
- R3: With the attribute select high, A4..A3 choose the region: 00 glyph pointer, 01 glyph row, 10 control byte, 11 character byte.
- R4: A character write stores all eight data bits at position A2..A0, where 0 is leftmost and 7 is rightmost. The scan port returns the byte held at the requested position.
- R5: The glyph pointer keeps D3..D0 only, and reads back with D7..D4 as zero.
- R6: A glyph row write stores D4..D0 into row A2..A0 of the glyph named by the pointer. D4 is the leftmost pixel, and D7..D5 are dropped. Rows 0 to 6 exist; a write to row 7 is dropped and a read of row 7 returns 0.
- R7: A control write replaces all writable control bits at once: D2..D0 intensity, D3 attribute enable, D4 global blink, D6 self-test start, D7 clear. D5 is read-only and reads the self-test result input.
- R8: A control write with D7 set loads 20h into every character and 0 into every attribute in the commit cycle. Busy then rises. Busy falls on the edge of the third display tick after the commit. D7 reads 1 until busy falls and 0 afterwards. The pointer, the glyph rows and the other control bits keep their values.
- R9: While reset is low, every character holds 20h and every attribute and control bit holds 0, and busy is high. Busy falls on the edge of the third display tick after reset is released. Glyph rows and the pointer keep their values across reset.
- R10: While busy is high, host writes to every region are dropped.
- R11: The block drives the data bus only while chip select and read strobe are both low, returning the addressed region's content; otherwise the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_attr_n | input | 1 | Attribute-region select, active low |
| bus_addr | input | 5 | Region and index address |
| bus_data | inout | 8 | Bidirectional data bus |
| disp_tick | input | 1 | One-cycle pulse per display clock |
| selftest_pass | input | 1 | Self-test result, read back in control bit 5 |
| scan_digit | input | 3 | Position read by the scan logic |
| udc_sel | input | 4 | Glyph read by the font logic |
| udc_row | input | 3 | Glyph row read by the font logic |
| busy | output | 1 | Clear or reset sequence in progress |
| char_code | output | 8 | Character byte at scan_digit |
| attr_bit | output | 1 | Attribute bit at scan_digit |
| udc_dots | output | 5 | Pixels of the selected glyph row |
| bright | output | 3 | Intensity code |
| flash_en | output | 1 | Attribute enable |
| blink_en | output | 1 | Global blink enable |
| selftest_go | output | 1 | Self-test start request |

## Verification
The bench drives writes in which the data changes after the commit cycle. A design that samples on every low cycle, instead of once per chip-select period, would store the late value. It writes the attribute region with nonzero A4..A3 and with every bit of the data set. A decoder that looked at A4..A3, or a store that took any bit other than D0, would corrupt the wrong position or the wrong region. It also targets glyph row 7 and the bits above D4, both of which must be dropped. It issues writes while a clear is still counting ticks, then confirms that the pointer, the glyph rows and the non-clear control bits survive both a clear and a reset. A sequencer that counted edges instead of ticks, or that blanked too much, shows up as a busy or content mismatch on the per-cycle comparison.

// File: rtl/dispreg_pkg.sv
package dispreg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SPACE_CODE = 8'h20;

  typedef enum logic [1:0] {
    RGN_UDC_PTR = 2'b00,
    RGN_UDC_ROW = 2'b01,
    RGN_CTRL    = 2'b10,
    RGN_CHAR    = 2'b11
  } region_e;

  typedef struct packed {
    logic       clr;
    logic       st_go;
    logic       blink;
    logic       flash_en;
    logic [2:0] bright;
  } ctrl_t;
endpackage

// File: rtl/dispreg_bus_sync.sv
module dispreg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic wr_n,
  output logic wr_fire
);
  logic [STAGES-1:0] ce_q, wr_q;
  logic [STAGES:0]   ce_d, wr_d;
  logic              act, act_q;

  always_comb begin
    ce_d = {ce_q, ce_n};
    wr_d = {wr_q, wr_n};
    act  = ~ce_q[STAGES-1] & ~wr_q[STAGES-1];
    wr_fire = act & ~act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= '1;
      wr_q  <= '1;
      act_q <= 1'b0;
    end else begin
      ce_q  <= ce_d[STAGES-1:0];
      wr_q  <= wr_d[STAGES-1:0];
      act_q <= act;
    end
  end
endmodule

// File: rtl/dispreg_seq.sv
module dispreg_seq #(
  parameter int TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    done   = busy_q & tick & (cnt_q == CW'(TICKS - 1));
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else if (tick) begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/dispreg_store.sv
module dispreg_store
  import dispreg_pkg::*;
#(
  parameter int DIGITS = 8,
  parameter int UDC_N  = 16,
  parameter int ROWS   = 7,
  parameter int COLS   = 5,
  localparam int DAW   = $clog2(DIGITS),
  localparam int UAW   = $clog2(UDC_N),
  localparam int RAW   = $clog2(ROWS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_fire,
  input  logic                          busy,
  input  logic                          seq_done,
  input  logic                          sel_n,
  input  logic [DAW+1:0]                addr,
  input  logic [BYTE_W-1:0]             wdata,
  input  logic                          st_pass,
  input  logic [UAW-1:0]                udc_sel,
  input  logic [DAW-1:0]                udc_row,
  output logic [BYTE_W-1:0]             rdata,
  output logic                          clr_start,
  output logic [DIGITS-1:0][BYTE_W-1:0] char_all,
  output logic [DIGITS-1:0]             flash_all,
  output ctrl_t                         ctrl,
  output logic [COLS-1:0]               udc_dots
);
  region_e                       rgn;
  logic [DAW-1:0]                lo;
  logic                          wr_ok, flash_we, ptr_we, row_we, ctrl_we, char_we;
  logic [DIGITS-1:0][BYTE_W-1:0] char_q, char_d;
  logic [DIGITS-1:0]             flash_q, flash_d;
  ctrl_t                         ctrl_q, ctrl_d;
  logic [UAW-1:0]                ptr_q;
  logic [COLS-1:0]               udc_q [UDC_N][ROWS];

  always_comb begin
    rgn      = region_e'(addr[DAW+1:DAW]);
    lo       = addr[DAW-1:0];
    wr_ok    = wr_fire & ~busy;
    flash_we = wr_ok & ~sel_n;
    ptr_we   = wr_ok & sel_n & (rgn == RGN_UDC_PTR);
    row_we   = wr_ok & sel_n & (rgn == RGN_UDC_ROW) & (int'(lo) < ROWS);
    ctrl_we  = wr_ok & sel_n & (rgn == RGN_CTRL);
    char_we  = wr_ok & sel_n & (rgn == RGN_CHAR);
    clr_start = ctrl_we & wdata[7];
  end

  // next state of the resettable storage
  always_comb begin
    char_d  = char_q;
    flash_d = flash_q;
    ctrl_d  = ctrl_q;
    if (clr_start) begin
      char_d  = {DIGITS{SPACE_CODE}};
      flash_d = '0;
    end else begin
      if (char_we)  char_d[lo]  = wdata;
      if (flash_we) flash_d[lo] = wdata[0];
    end
    if (ctrl_we) begin
      ctrl_d.clr      = wdata[7];
      ctrl_d.st_go    = wdata[6];
      ctrl_d.blink    = wdata[4];
      ctrl_d.flash_en = wdata[3];
      ctrl_d.bright   = wdata[2:0];
    end else if (seq_done) begin
      ctrl_d.clr = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q  <= {DIGITS{SPACE_CODE}};
      flash_q <= '0;
      ctrl_q  <= '0;
    end else begin
      char_q  <= char_d;
      flash_q <= flash_d;
      ctrl_q  <= ctrl_d;
    end
  end

  // glyph storage is kept across reset and clear
  always_ff @(posedge clk) begin
    if (ptr_we) ptr_q <= wdata[UAW-1:0];
  end

  always_ff @(posedge clk) begin
    if (row_we) udc_q[ptr_q][lo[RAW-1:0]] <= wdata[COLS-1:0];
  end

  always_comb begin
    rdata = '0;
    if (!sel_n) begin
      rdata[0] = flash_q[lo];
    end else begin
      unique case (rgn)
        RGN_UDC_PTR: rdata = BYTE_W'(ptr_q);
        RGN_UDC_ROW: rdata = (int'(lo) < ROWS) ? BYTE_W'(udc_q[ptr_q][lo[RAW-1:0]]) : '0;
        RGN_CTRL:    rdata = {ctrl_q.clr, ctrl_q.st_go, st_pass, ctrl_q.blink,
                              ctrl_q.flash_en, ctrl_q.bright};
        default:     rdata = char_q[lo];
      endcase
    end
    udc_dots = (int'(udc_row) < ROWS) ? udc_q[udc_sel][udc_row[RAW-1:0]] : '0;
  end

  assign char_all  = char_q;
  assign flash_all = flash_q;
  assign ctrl      = ctrl_q;
endmodule

// File: rtl/dispreg_host_if.sv
module dispreg_host_if
  import dispreg_pkg::*;
#(
  parameter int DIGITS      = 8,
  parameter int UDC_N       = 16,
  parameter int UDC_ROWS    = 7,
  parameter int UDC_COLS    = 5,
  parameter int SYNC_STAGES = 2,
  parameter int SEQ_TICKS   = 3,
  localparam int DAW        = $clog2(DIGITS),
  localparam int UAW        = $clog2(UDC_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_ce_n,
  input  logic                bus_rd_n,
  input  logic                bus_wr_n,
  input  logic                bus_attr_n,
  input  logic [DAW+1:0]      bus_addr,
  inout  wire  [BYTE_W-1:0]   bus_data,
  input  logic                disp_tick,
  input  logic                selftest_pass,
  input  logic [DAW-1:0]      scan_digit,
  input  logic [UAW-1:0]      udc_sel,
  input  logic [DAW-1:0]      udc_row,
  output logic                busy,
  output logic [BYTE_W-1:0]   char_code,
  output logic                attr_bit,
  output logic [UDC_COLS-1:0] udc_dots,
  output logic [2:0]          bright,
  output logic                flash_en,
  output logic                blink_en,
  output logic                selftest_go
);
  logic                          wr_fire, seq_done, clr_start, rd_drive;
  logic [BYTE_W-1:0]             rdata;
  logic [DIGITS-1:0][BYTE_W-1:0] char_all;
  logic [DIGITS-1:0]             flash_all;
  ctrl_t                         ctrl;

  dispreg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(bus_ce_n), .wr_n(bus_wr_n), .wr_fire(wr_fire)
  );

  dispreg_seq #(.TICKS(SEQ_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(disp_tick), .start(clr_start),
    .busy(busy), .done(seq_done)
  );

  dispreg_store #(
    .DIGITS(DIGITS), .UDC_N(UDC_N), .ROWS(UDC_ROWS), .COLS(UDC_COLS)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .busy(busy), .seq_done(seq_done),
    .sel_n(bus_attr_n), .addr(bus_addr), .wdata(bus_data), .st_pass(selftest_pass),
    .udc_sel(udc_sel), .udc_row(udc_row), .rdata(rdata), .clr_start(clr_start),
    .char_all(char_all), .flash_all(flash_all), .ctrl(ctrl), .udc_dots(udc_dots)
  );

  assign rd_drive    = ~bus_ce_n & ~bus_rd_n;
  assign bus_data    = rd_drive ? rdata : 'z;
  assign char_code   = char_all[scan_digit];
  assign attr_bit    = flash_all[scan_digit];
  assign bright      = ctrl.bright;
  assign flash_en    = ctrl.flash_en;
  assign blink_en    = ctrl.blink;
  assign selftest_go = ctrl.st_go;
endmodule

// File: rtl/dispreg_host_if_chk.sv
module dispreg_host_if_chk #(
  parameter int DIGITS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   disp_tick,
  input logic                   busy,
  input logic [DIGITS-1:0][7:0] char_all,
  input logic [DIGITS-1:0]      flash_all,
  input logic [2:0]             bright,
  input logic                   flash_en,
  input logic                   blink_en,
  input logic                   selftest_go
);
  // R8: the sequence ends only on a display tick
  p_busy_ends_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(disp_tick));

  // R8: without a tick the sequence keeps running
  p_busy_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !disp_tick) |=> busy);

  // R8: attributes stay removed for the whole sequence
  p_flash_clear_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (flash_all == '0));

  // R9: characters stay blank for the whole sequence
  p_char_space_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (char_all == {DIGITS{8'h20}}));

  // R10: control outputs cannot move while writes are locked out
  p_ctrl_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({bright, flash_en, blink_en, selftest_go}));
endmodule

bind dispreg_host_if dispreg_host_if_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_tick(disp_tick), .busy(busy),
  .char_all(char_all), .flash_all(flash_all), .bright(bright),
  .flash_en(flash_en), .blink_en(blink_en), .selftest_go(selftest_go)
);

// File: tb/dispreg_host_if_bench.sv
module dispreg_host_if_bench;
  logic       clk, rst_n;
  logic       ce_n, rd_n, wr_n, attr_n;
  logic [4:0] addr;
  logic [7:0] tb_d;
  logic       tb_oe;
  wire  [7:0] bus_d;
  logic       disp_tick, st_pass;
  logic [2:0] scan_digit, udc_row;
  logic [3:0] udc_sel;
  logic       busy, attr_bit, flash_en, blink_en, selftest_go;
  logic [7:0] char_code;
  logic [4:0] udc_dots;
  logic [2:0] bright;

  int total = 0, bad = 0, tick_cnt = 0;
  bit finished = 0;

  assign bus_d = tb_oe ? tb_d : 8'bz;

  dispreg_host_if u_dispreg_host_if (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
    .bus_attr_n(attr_n), .bus_addr(addr), .bus_data(bus_d), .disp_tick(disp_tick),
    .selftest_pass(st_pass), .scan_digit(scan_digit), .udc_sel(udc_sel),
    .udc_row(udc_row), .busy(busy), .char_code(char_code), .attr_bit(attr_bit),
    .udc_dots(udc_dots), .bright(bright), .flash_en(flash_en), .blink_en(blink_en),
    .selftest_go(selftest_go)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_char [8];
  bit         m_flash [8];
  logic [7:0] m_ctrl;
  int         m_ptr = -1;
  logic [4:0] m_udc [16][8];
  bit         m_udc_v [16][8];
  bit         m_busy;
  int         m_ticks;
  bit         h1, h2, pa, act_s, fire;

  task m_apply(input logic sel_n, input logic [4:0] a, input logic [7:0] d);
    if (!sel_n) m_flash[a[2:0]] = d[0];
    else case (a[4:3])
      2'b00: m_ptr = int'(d[3:0]);
      2'b01: if (a[2:0] != 3'd7 && m_ptr >= 0) begin
               m_udc[m_ptr][a[2:0]] = d[4:0];
               m_udc_v[m_ptr][a[2:0]] = 1;
             end
      2'b10: begin
               m_ctrl = d & 8'hDF;
               if (d[7]) begin
                 for (int i = 0; i < 8; i++) begin m_char[i] = 8'h20; m_flash[i] = 0; end
                 m_busy = 1; m_ticks = 0;
               end
             end
      default: m_char[a[2:0]] = d;
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; pa = 0; m_busy = 1; m_ticks = 0; m_ctrl = 8'h00;
      for (int i = 0; i < 8; i++) begin m_char[i] = 8'h20; m_flash[i] = 0; end
    end else begin
      act_s = h2;
      fire  = act_s && !pa;
      pa    = act_s;
      h2    = h1;
      h1    = (ce_n == 1'b0) && (wr_n == 1'b0);
      if (m_busy) begin
        if (disp_tick) begin
          m_ticks++;
          if (m_ticks == 3) begin m_busy = 0; m_ticks = 0; m_ctrl[7] = 1'b0; end
        end
      end else if (fire) begin
        m_apply(attr_n, addr, tb_d);
      end
    end
  end

  function automatic logic [7:0] m_read(input logic sel_n, input logic [4:0] a);
    if (!sel_n) return {7'b0, m_flash[a[2:0]]};
    case (a[4:3])
      2'b00: return 8'(m_ptr);
      2'b01: return (a[2:0] == 3'd7) ? 8'h00 : {3'b0, m_udc[m_ptr][a[2:0]]};
      2'b10: return {m_ctrl[7:6], st_pass, m_ctrl[4:0]};
      default: return m_char[a[2:0]];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R10 busy", 8'(busy), 8'(m_busy));
      chk("R4 scan char", char_code, m_char[scan_digit]);
      chk("R2 scan attr", 8'(attr_bit), 8'(m_flash[scan_digit]));
      chk("R7 ctrl outputs", {4'b0, selftest_go, blink_en, flash_en, bright[2]},
          {4'b0, m_ctrl[6], m_ctrl[4], m_ctrl[3], m_ctrl[2]});
      chk("R7 bright", 8'(bright), 8'(m_ctrl[2:0]));
      if (m_udc_v[udc_sel][udc_row]) chk("R6 glyph dots", 8'(udc_dots), 8'(m_udc[udc_sel][udc_row]));
    end
  end

  // display ticks and scan stimulus
  always @(negedge clk) begin
    tick_cnt  = (tick_cnt == 6) ? 0 : tick_cnt + 1;
    disp_tick = (tick_cnt == 0);
    scan_digit = scan_digit + 3'd1;
    udc_row    = (udc_row == 3'd7) ? 3'd0 : udc_row + 3'd1;
    if (udc_row == 3'd0) udc_sel = udc_sel + 4'd3;
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic sel_n, input logic [4:0] a, input logic [7:0] d,
                           input logic [7:0] late_d, input bit change);
    @(negedge clk);
    attr_n = sel_n; addr = a; tb_d = d; tb_oe = 1; ce_n = 0; wr_n = 0;
    repeat (3) @(negedge clk);
    if (change) tb_d = late_d;   // after the commit edge
    repeat (2) @(negedge clk);
    wr_n = 1; ce_n = 1;
    @(negedge clk);
    tb_oe = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic sel_n, input logic [4:0] a, input logic [7:0] d);
    bus_write(sel_n, a, d, 8'h00, 0);
  endtask

  task automatic bus_read(input string tag, input logic sel_n, input logic [4:0] a);
    @(negedge clk);
    attr_n = sel_n; addr = a; ce_n = 0; rd_n = 0;
    #1;
    chk(tag, bus_d, m_read(sel_n, a));
    @(negedge clk);
    ce_n = 1; rd_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 200) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ce_n = 1; rd_n = 1; wr_n = 1; attr_n = 1; addr = 0; tb_d = 0; tb_oe = 0;
    st_pass = 0; disp_tick = 0; scan_digit = 0; udc_row = 0; udc_sel = 0;
    repeat (3) @(negedge clk);
    chk("R9 busy in reset", 8'(busy), 8'h01);
    chk("R9 char blank in reset", char_code, 8'h20);
    rst_n = 1;
    wait_idle();
    chk("R9 busy released", 8'(busy), 8'h00);
    bus_read("R9 char after reset", 1, 5'b11_011);
    bus_read("R9 ctrl after reset", 1, 5'b10_000);

    // R3/R4: character region, including a glyph reference
    wr(1, 5'b11_000, 8'h48);
    wr(1, 5'b11_111, 8'h83);
    wr(1, 5'b11_100, 8'h7F);
    bus_read("R4 leftmost char", 1, 5'b11_000);
    bus_read("R4 rightmost char", 1, 5'b11_111);

    // R2: attribute region ignores A4..A3 and stores only D0
    wr(0, 5'b11_010, 8'h01);
    wr(0, 5'b01_101, 8'hFF);
    wr(0, 5'b10_101, 8'hFE);
    bus_read("R2 attr set", 0, 5'b00_010);
    bus_read("R2 attr removed", 0, 5'b11_101);

    // R5: glyph pointer
    wr(1, 5'b00_110, 8'hA7);
    bus_read("R5 pointer low nibble", 1, 5'b00_000);

    // R6: glyph rows
    for (int r = 0; r < 7; r++) wr(1, {2'b01, 3'(r)}, 8'hE0 | 8'(5'h11 + r));
    wr(1, 5'b01_111, 8'h1F);
    bus_read("R6 row 3 drops upper bits", 1, 5'b01_011);
    bus_read("R6 row 7 reads zero", 1, 5'b01_111);
    wr(1, 5'b00_000, 8'h02);
    wr(1, 5'b01_000, 8'h15);
    bus_read("R6 second glyph", 1, 5'b01_000);
    wr(1, 5'b00_000, 8'h07);

    // R7: control byte, bit 5 from input
    wr(1, 5'b10_000, 8'h7B);
    bus_read("R7 ctrl readback", 1, 5'b10_000);
    st_pass = 1;
    bus_read("R7 selftest result bit", 1, 5'b10_000);

    // R1: late data change inside one chip-select period
    bus_write(1, 5'b11_001, 8'h41, 8'h5A, 1);
    bus_read("R1 single commit", 1, 5'b11_001);

    // R11: bus released after a read, next write lands intact
    wr(1, 5'b11_010, 8'hC3);
    bus_read("R11 write after read", 1, 5'b11_010);

    // R8/R10: clear sequence, writes dropped while busy
    wr(1, 5'b10_000, 8'h93);
    chk("R8 busy after clear", 8'(busy), 8'h01);
    bus_read("R8 clear bit while busy", 1, 5'b10_000);
    wr(1, 5'b11_000, 8'h55);
    wr(0, 5'b00_000, 8'h01);
    wait_idle();
    bus_read("R10 write during busy dropped", 1, 5'b11_000);
    bus_read("R10 attr during busy dropped", 0, 5'b00_000);
    bus_read("R8 clear bit released", 1, 5'b10_000);
    bus_read("R8 pointer kept", 1, 5'b00_000);
    bus_read("R8 glyph row kept", 1, 5'b01_100);

    // R9: reset in mid-use keeps glyph storage
    wr(1, 5'b11_101, 8'h39);
    wr(1, 5'b10_000, 8'h4D);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R9 ctrl cleared by reset", 8'(bright), 8'h00);
    chk("R9 busy during reset", 8'(busy), 8'h01);
    @(negedge clk);
    rst_n = 1;
    wait_idle();
    bus_read("R9 char blank after reset", 1, 5'b11_101);
    bus_read("R9 pointer kept", 1, 5'b00_000);
    bus_read("R9 glyph row kept", 1, 5'b01_010);
    bus_read("R9 ctrl zero", 1, 5'b10_000);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule